// File: doc/BRIEF.md
# Serial Bitstream Configuration Sequencer

This block loads a configuration image into an attached programmable device over a serial clock and data pair. On a start pulse it pulls the device's active-low configuration reset low for a set time and then releases it. It waits while the device wipes its configuration memory, then issues a group of dummy clock pulses with chip select high. Next it shifts the image out, most significant bit first, with chip select low. It sends a second group of dummy pulses with chip select high and finally samples the device's configuration-done line to decide between success and failure.

Image bytes arrive on a plain valid/ready byte port. A side flag marks the final byte. The serial clock is held low while the sequencer waits for the next byte, so an uneven supply of data only stretches the transfer. All delays are given in microseconds and converted with a system-clocks-per-microsecond parameter. The serial clock's high and low phases each last a parameterised number of system clocks.

Top module: `bitload_seq`

## Requirements
- R1: After reset the block is idle: cfg_rst_n=1, cfg_cs_n=1, cfg_sclk=0, busy=0, done=0, error=0, in_ready=0.
- R2: A start pulse sampled while idle, done or in error starts a new load. It clears done and error, sets busy, and drives cfg_rst_n low for exactly RESET_US*CLKS_PER_US cycles, beginning the cycle after start is sampled. During that time cfg_sclk=0 and cfg_cs_n=1.
- R3: After reset release, the block waits exactly CLEAR_US*CLKS_PER_US cycles with cfg_rst_n=1, cfg_cs_n=1 and cfg_sclk=0.
- R4: It then issues LEAD_PULSES serial clock pulses with cfg_cs_n=1. Each pulse is HALF_CLKS cycles low followed by HALF_CLKS cycles high.
- R5: cfg_cs_n is low from the end of the last leading pulse until the falling serial edge that ends the final payload bit, and high at every other time.
- R6: Each byte is sent most significant bit first. A bit is on cfg_sdo for its full low and high phase, and cfg_sdo changes only together with a falling serial edge or while the clock is parked.
- R7: in_ready is 1 only while a byte is awaited with chip select low, and cfg_sclk stays low meanwhile. in_valid has no effect at any other time. After a byte is taken, its first bit's low phase lasts HALF_CLKS cycles.
- R8: The byte taken with in_last=1 is the final byte. After its eighth bit, TRAIL_PULSES pulses follow with cfg_cs_n=1.
- R9: One cycle after the trailing pulses (busy still 1), the block ends with busy=0. It sets done=1 if the synchronised cfg_done_in is 1, and error=1 otherwise. The result holds until the next start.
- R10: A start pulse while busy is ignored and does not disturb the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (ignored while busy) |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | Current byte is the final one |
| in_ready | output | 1 | Sequencer takes the byte this cycle if valid |
| cfg_done_in | input | 1 | Configuration-done line from the device (asynchronous) |
| cfg_sclk | output | 1 | Serial clock to the device |
| cfg_sdo | output | 1 | Serial data to the device |
| cfg_cs_n | output | 1 | Active-low chip select to the device |
| cfg_rst_n | output | 1 | Active-low configuration reset to the device |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load succeeded |
| error | output | 1 | Last load ended with the done line low |

## Verification
The hardest situation to reach from the ports is a payload that stalls between bytes while the serial clock is parked. The half-period counter must restart cleanly, and chip select must stay low through the gap. The bench feeds bytes with differing gaps, including none and several cycles. It holds in_valid high with junk data during the leading pulses to show the byte port is closed there. A second run ends with the done line low and pulses start in the middle of the memory-clear wait, so the error path and the ignored start are both reached. A third run then restarts from the error state.

// File: rtl/bitload_pkg.sv
package bitload_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RESET,
    ST_CLEAR,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_CHECK,
    ST_DONE,
    ST_ERROR
  } seq_state_e;

endpackage

// File: rtl/bitload_sync2.sv
module bitload_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_in;
      sync_q <= meta_q;
    end
  end

  assign d_out = sync_q;

endmodule

// File: rtl/bitload_halfper.sv
module bitload_halfper #(
  parameter int HALF_CLKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall
);

  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          tick;

  assign tick = run && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
  assign fall = tick && sclk_q;

  // R4: a stopped generator parks the clock low on the next cycle
  a_r4_park_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);

endmodule

// File: rtl/bitload_shifter.sv
module bitload_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          last_in,
  input  logic          shift,
  output logic          sdo,
  output logic          loaded,
  output logic          last_q,
  output logic          byte_end
);

  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

  logic [DW-1:0] sh_q, sh_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          ld_q, ld_d;
  logic          last_d, last_r;

  assign byte_end = shift && ld_q && (bit_q == BIT_LAST);

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    ld_d   = ld_q;
    last_d = last_r;
    if (load) begin
      sh_d   = din;
      bit_d  = '0;
      ld_d   = 1'b1;
      last_d = last_in;
    end else if (shift && ld_q) begin
      sh_d  = {sh_q[DW-2:0], 1'b0};
      bit_d = bit_q + 1'b1;
      if (bit_q == BIT_LAST) begin
        ld_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      ld_q   <= 1'b0;
      last_r <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      ld_q   <= ld_d;
      last_r <= last_d;
    end
  end

  assign sdo    = sh_q[DW-1];
  assign loaded = ld_q;
  assign last_q = last_r;

  // R7: a new byte is never taken over one that is still being sent
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !ld_q);

endmodule

// File: rtl/bitload_seq.sv
module bitload_seq
  import bitload_pkg::*;
#(
  parameter int CLKS_PER_US  = 12,
  parameter int RESET_US     = 1,
  parameter int CLEAR_US     = 1200,
  parameter int LEAD_PULSES  = 8,
  parameter int TRAIL_PULSES = 49,
  parameter int HALF_CLKS    = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       cfg_done_in,
  output logic       cfg_sclk,
  output logic       cfg_sdo,
  output logic       cfg_cs_n,
  output logic       cfg_rst_n,
  output logic       busy,
  output logic       done,
  output logic       error
);

  localparam int RST_CYC = RESET_US * CLKS_PER_US;
  localparam int CLR_CYC = CLEAR_US * CLKS_PER_US;
  localparam int MAX_CYC = (RST_CYC > CLR_CYC) ? RST_CYC : CLR_CYC;
  localparam int DLY_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam int MAX_PUL = (LEAD_PULSES > TRAIL_PULSES) ? LEAD_PULSES : TRAIL_PULSES;
  localparam int PUL_W   = (MAX_PUL > 1) ? $clog2(MAX_PUL) : 1;
  localparam logic [DLY_W-1:0] RST_LAST   = DLY_W'(RST_CYC - 1);
  localparam logic [DLY_W-1:0] CLR_LAST   = DLY_W'(CLR_CYC - 1);
  localparam logic [PUL_W-1:0] LEAD_LAST  = PUL_W'(LEAD_PULSES - 1);
  localparam logic [PUL_W-1:0] TRAIL_LAST = PUL_W'(TRAIL_PULSES - 1);

  seq_state_e        st_q, st_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic [PUL_W-1:0]  pul_q, pul_d;

  logic done_sync;
  logic clk_run;
  logic sclk_int;
  logic fall;
  logic sh_load;
  logic sh_shift;
  logic sh_sdo;
  logic sh_loaded;
  logic sh_last;
  logic sh_byte_end;

  bitload_sync2 u_done_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (cfg_done_in),
    .d_out (done_sync)
  );

  assign clk_run = (st_q == ST_LEAD) || (st_q == ST_TRAIL) ||
                   ((st_q == ST_SHIFT) && sh_loaded);

  bitload_halfper #(
    .HALF_CLKS (HALF_CLKS)
  ) u_halfper (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (clk_run),
    .sclk  (sclk_int),
    .fall  (fall)
  );

  assign in_ready = (st_q == ST_SHIFT) && !sh_loaded;
  assign sh_load  = in_ready && in_valid;
  assign sh_shift = fall && (st_q == ST_SHIFT);

  bitload_shifter #(
    .DW (8)
  ) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .din      (in_data),
    .last_in  (in_last),
    .shift    (sh_shift),
    .sdo      (sh_sdo),
    .loaded   (sh_loaded),
    .last_q   (sh_last),
    .byte_end (sh_byte_end)
  );

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    pul_d = pul_q;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_ERROR: begin
        if (start) begin
          st_d  = ST_RESET;
          dly_d = '0;
        end
      end
      ST_RESET: begin
        if (dly_q == RST_LAST) begin
          st_d  = ST_CLEAR;
          dly_d = '0;
        end else begin
          dly_d = dly_q + 1'b1;
        end
      end
      ST_CLEAR: begin
        if (dly_q == CLR_LAST) begin
          st_d  = ST_LEAD;
          dly_d = '0;
          pul_d = '0;
        end else begin
          dly_d = dly_q + 1'b1;
        end
      end
      ST_LEAD: begin
        if (fall) begin
          if (pul_q == LEAD_LAST) begin
            st_d  = ST_SHIFT;
            pul_d = '0;
          end else begin
            pul_d = pul_q + 1'b1;
          end
        end
      end
      ST_SHIFT: begin
        if (sh_byte_end && sh_last) begin
          st_d  = ST_TRAIL;
          pul_d = '0;
        end
      end
      ST_TRAIL: begin
        if (fall) begin
          if (pul_q == TRAIL_LAST) begin
            st_d  = ST_CHECK;
            pul_d = '0;
          end else begin
            pul_d = pul_q + 1'b1;
          end
        end
      end
      ST_CHECK: begin
        st_d = done_sync ? ST_DONE : ST_ERROR;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dly_q <= '0;
      pul_q <= '0;
    end else begin
      st_q  <= st_d;
      dly_q <= dly_d;
      pul_q <= pul_d;
    end
  end

  assign cfg_sclk  = sclk_int;
  assign cfg_sdo   = sh_sdo;
  assign cfg_cs_n  = (st_q != ST_SHIFT);
  assign cfg_rst_n = (st_q != ST_RESET);
  assign busy      = (st_q != ST_IDLE) && (st_q != ST_DONE) && (st_q != ST_ERROR);
  assign done      = (st_q == ST_DONE);
  assign error     = (st_q == ST_ERROR);

  // R2: no serial activity while the device is held in reset
  a_r2_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rst_n |-> (!cfg_sclk && cfg_cs_n));

  // R5: chip select only moves while the serial clock is low
  a_r5_cs_edge_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_cs_n) |-> !cfg_sclk);

  // R6: data is held through every high phase
  a_r6_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sclk && $past(cfg_sclk)) |-> $stable(cfg_sdo));

  // R7: the clock is parked low while a byte is awaited
  a_r7_wait_low: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cfg_sclk);

  // R9: a result is only reported after the check step
  a_r9_result_from_check: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) || $rose(error)) |-> ($past(st_q) == ST_CHECK));

  // R9: success and failure are never flagged together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

endmodule

// File: tb/bitload_seq_tb.sv
module bitload_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CPU   = 2;
  localparam int RUS   = 2;
  localparam int CUS   = 3;
  localparam int NLEAD = 3;
  localparam int NTRL  = 5;
  localparam int HALF  = 2;
  localparam int RCYC  = RUS * CPU;
  localparam int CCYC  = CUS * CPU;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_last;
  logic       in_ready;
  logic       cfg_done_in;
  logic       cfg_sclk;
  logic       cfg_sdo;
  logic       cfg_cs_n;
  logic       cfg_rst_n;
  logic       busy;
  logic       done;
  logic       error;

  int total;
  int bad;
  logic exp_done;
  logic exp_err;
  logic [7:0] bytes_q[$];
  int         gaps_q[$];

  bitload_seq #(
    .CLKS_PER_US  (CPU),
    .RESET_US     (RUS),
    .CLEAR_US     (CUS),
    .LEAD_PULSES  (NLEAD),
    .TRAIL_PULSES (NTRL),
    .HALF_CLKS    (HALF)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .in_data     (in_data),
    .in_valid    (in_valid),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .cfg_done_in (cfg_done_in),
    .cfg_sclk    (cfg_sclk),
    .cfg_sdo     (cfg_sdo),
    .cfg_cs_n    (cfg_cs_n),
    .cfg_rst_n   (cfg_rst_n),
    .busy        (busy),
    .done        (done),
    .error       (error)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic cmp1(input logic act, input logic exp, input string nm,
                      input string tag, inout bit ok);
    if (act !== exp) begin
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
      ok = 1'b0;
    end
  endtask

  task automatic chk(input logic e_rst, input logic e_cs, input logic e_sclk,
                     input logic e_busy, input logic e_rdy,
                     input logic e_sdo, input bit use_sdo, input string tag);
    bit ok;
    @(negedge clk);
    ok = 1'b1;
    total++;
    cmp1(cfg_rst_n, e_rst, "cfg_rst_n", tag, ok);
    cmp1(cfg_cs_n, e_cs, "cfg_cs_n", tag, ok);
    cmp1(cfg_sclk, e_sclk, "cfg_sclk", tag, ok);
    cmp1(busy, e_busy, "busy", tag, ok);
    cmp1(in_ready, e_rdy, "in_ready", tag, ok);
    cmp1(done, exp_done, "done", tag, ok);
    cmp1(error, exp_err, "error", tag, ok);
    if (use_sdo) cmp1(cfg_sdo, e_sdo, "cfg_sdo", tag, ok);
    if (!ok) bad++;
  endtask

  task automatic pulses(input int n, input string tag);
    for (int p = 0; p < n; p++) begin
      for (int k = 0; k < HALF; k++) chk(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, tag);
      for (int k = 0; k < HALF; k++) chk(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, tag);
    end
  endtask

  task automatic run_load(input logic done_lvl, input bit poke);
    int nb;
    nb = bytes_q.size();
    cfg_done_in = done_lvl;
    start = 1'b1;
    exp_done = 1'b0;
    exp_err  = 1'b0;
    for (int i = 0; i < RCYC; i++) begin
      chk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
      start = 1'b0;
    end
    for (int i = 0; i < CCYC; i++) begin
      chk(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, poke ? "R3 R10" : "R3");
      start = poke && (i == 1);
    end
    start = 1'b0;
    // leading pulses; junk offered on the byte port must be ignored (R7)
    in_valid = 1'b1;
    in_data  = 8'hFF;
    in_last  = 1'b1;
    pulses(NLEAD, "R4 R7");
    in_valid = 1'b0;
    in_last  = 1'b0;
    for (int b = 0; b < nb; b++) begin
      for (int g = 0; g <= gaps_q[b]; g++) begin
        chk(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 R7");
        if (g == gaps_q[b]) begin
          in_valid = 1'b1;
          in_data  = bytes_q[b];
          in_last  = (b == nb - 1);
        end
      end
      for (int bi = 7; bi >= 0; bi--) begin
        for (int k = 0; k < HALF; k++) begin
          chk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, bytes_q[b][bi], 1'b1, "R5 R6");
          in_valid = 1'b0;
          in_data  = 8'h00;
          in_last  = 1'b0;
        end
        for (int k = 0; k < HALF; k++)
          chk(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, bytes_q[b][bi], 1'b1, "R5 R6");
      end
    end
    pulses(NTRL, "R8");
    chk(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    exp_done = done_lvl;
    exp_err  = !done_lvl;
    for (int i = 0; i < 4; i++) chk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
  endtask

  initial begin
    total = 0;
    bad = 0;
    exp_done = 1'b0;
    exp_err  = 1'b0;
    rst_n = 1'b0;
    start = 1'b0;
    in_data = 8'h00;
    in_valid = 1'b0;
    in_last = 1'b0;
    cfg_done_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) chk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

    bytes_q = '{8'hA5, 8'h3C, 8'h81};
    gaps_q  = '{0, 2, 1};
    run_load(1'b1, 1'b0);

    bytes_q = '{8'h5E};
    gaps_q  = '{3};
    run_load(1'b0, 1'b1);

    bytes_q = '{8'h00, 8'hFF};
    gaps_q  = '{1, 0};
    run_load(1'b1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule